// File: doc/BRIEF.md
# Edge-Capture and Compare Channel

This block is one channel of a compare/capture array. All channels share one free-running counter. A 7-bit mode word selects what the channel does. In capture mode it snapshots the counter when a chosen transition appears on an external pin. In timer mode it raises an event when the counter reaches a programmed value. In high-speed-output mode it also inverts its pin output on that match.

The channel holds one 16-bit value, and software writes it as two bytes. A capture overwrites the same storage. Writing the low byte takes the comparator offline, and writing the high byte brings it back. This stops a half-written value from producing a false match.

The channel does not store the event flag. It only issues a one-cycle set strobe, and the flag is kept elsewhere.

Top module: `cc_channel`

## Requirements
- R1: After synchronous reset, the following read zero: the pin output, the event strobe, the 16-bit value and the mode word.
- R2: Mode bit 5 selects capture on rising edges. The pin passes through a two-flop synchronizer. If the pin is first sampled high at clock edge k (low at k-1), the value holds the counter input present at edge k+2, and the event strobe is high for the cycle that follows.
- R3: Mode bit 4 selects capture on falling edges. With only bit 4 set, a rising pin edge changes neither the value nor the event strobe.
- R4: With bits 5 and 4 both set, either transition captures, and each new capture overwrites the previous value.
- R5: Timer mode sets bits 6 and 3 and clears bits 5, 4, 2 and 1. The clock edge at which the counter input first equals the value is followed by exactly one strobe cycle. The pin output is not changed.
- R6: While the counter input stays equal to the value, no further strobe is issued.
- R7: High-speed-output mode is timer mode plus bit 2. On each match the pin output inverts at the same edge that raises the strobe.
- R8: A pin preset write forces the pin output to the supplied level. The preset wins over a toggle in the same cycle.
- R9: A low-byte write loads value bits 7:0 and clears mode bit 6. A high-byte write loads bits 15:8 and sets mode bit 6. No match fires while bit 6 is clear.
- R10: Any other mode combination is idle. Examples are bit 1 (PWM) set, toggle without match, match without bit 6, and capture bits together with match. An idle channel produces no strobe and no toggle.
- R11: The mode word reads back as written in bits 6:0. Bit 7 always reads zero. Bit 0 is stored but has no effect on the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| pin_in | input | 1 | External pin, asynchronous |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 7 | Mode word write data |
| lo_we | input | 1 | Low value byte write strobe |
| hi_we | input | 1 | High value byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| pin_set_we | input | 1 | Pin output preset strobe |
| pin_set_val | input | 1 | Pin output preset level |
| pin_out | output | 1 | Pin output |
| evt_set | output | 1 | One-cycle event flag set strobe |
| cap_q | output | 16 | Capture/compare value |
| mode_q | output | 8 | Mode word readback |

## Verification
The bench builds the channel with its default parameters: 8-bit bytes, a 16-bit value and a two-stage synchronizer. With these values, the exact three-edge capture latency is a fixed number the bench can predict. A 16-bit counter can be swept across a match value in a handful of cycles. The mode table covers every legal function and several illegal combinations. Directed cases cover the byte-write enable interlock, held-counter refire and preset-versus-toggle collision.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int MB_CMP_EN = 6;
  localparam int MB_CAP_R  = 5;
  localparam int MB_CAP_F  = 4;
  localparam int MB_MATCH  = 3;
  localparam int MB_TOG    = 2;
  localparam int MB_PWM    = 1;

  typedef enum logic [1:0] {OP_IDLE, OP_CAPT, OP_TIMER, OP_HSO} op_e;

  function automatic op_e mode_decode(input logic [6:0] m);
    op_e r;
    r = OP_IDLE;
    if (!m[MB_MATCH] && !m[MB_TOG] && !m[MB_PWM] && (m[MB_CAP_R] || m[MB_CAP_F]))
      r = OP_CAPT;
    else if (m[MB_CMP_EN] && !m[MB_CAP_R] && !m[MB_CAP_F] && m[MB_MATCH] && !m[MB_PWM])
      r = m[MB_TOG] ? OP_HSO : OP_TIMER;
    return r;
  endfunction
endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cc_match.sv
module cc_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         hit_o
);
  logic eq, eq_q;

  assign eq = (cnt_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  assign hit_o = en_i & eq & ~eq_q;

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] cnt_val,
  input  logic                pin_in,
  input  logic                mode_we,
  input  logic [6:0]          mode_wdata,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [BYTE_W-1:0]   byte_wdata,
  input  logic                pin_set_we,
  input  logic                pin_set_val,
  output logic                pin_out,
  output logic                evt_set,
  output logic [2*BYTE_W-1:0] cap_q,
  output logic [7:0]          mode_q
);
  import cc_pkg::*;

  localparam int VAL_W = 2 * BYTE_W;

  logic [6:0]       mode_r;
  logic [VAL_W-1:0] val_r;
  logic             pin_r, evt_r;
  logic             rise, fall, hit, cap_fire, tog_fire, cmp_on;
  op_e              op;

  assign op = mode_decode(mode_r);

  cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
  );

  assign cmp_on = (op == OP_TIMER) || (op == OP_HSO);

  cc_match #(.W(VAL_W)) u_match (
    .clk(clk), .rst(rst), .en_i(cmp_on), .cnt_i(cnt_val), .cmp_i(val_r), .hit_o(hit)
  );

  assign cap_fire = (op == OP_CAPT) &&
                    ((mode_r[MB_CAP_R] && rise) || (mode_r[MB_CAP_F] && fall));
  assign tog_fire = hit && (op == OP_HSO);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= '0;
      val_r  <= '0;
      pin_r  <= 1'b0;
      evt_r  <= 1'b0;
    end else begin
      if (mode_we) mode_r <= mode_wdata;
      if (lo_we)   mode_r[MB_CMP_EN] <= 1'b0;
      if (hi_we)   mode_r[MB_CMP_EN] <= 1'b1;

      if (cap_fire) val_r <= cnt_val;
      if (lo_we)    val_r[BYTE_W-1:0] <= byte_wdata;
      if (hi_we)    val_r[VAL_W-1:BYTE_W] <= byte_wdata;

      if (tog_fire)   pin_r <= ~pin_r;
      if (pin_set_we) pin_r <= pin_set_val;

      evt_r <= cap_fire | hit;
    end
  end

  assign pin_out = pin_r;
  assign evt_set = evt_r;
  assign cap_q   = val_r;
  assign mode_q  = {1'b0, mode_r};

  // R9
  lo_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_we && !hi_we) |=> !mode_q[6]);

  // R9
  hi_sets_chk: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> mode_q[6]);

  // R2
  capture_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_q != $past(cap_q) && !$past(lo_we) && !$past(hi_we)) |-> evt_set);

  // R7
  toggle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_out != $past(pin_out) && !$past(pin_set_we)) |-> evt_set);
endmodule

// File: tb/cc_channel_test.sv
module cc_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = '0;
  logic        pin_in = 1'b0;
  logic        mode_we = 1'b0;
  logic [6:0]  mode_wdata = '0;
  logic        lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0]  byte_wdata = '0;
  logic        pin_set_we = 1'b0, pin_set_val = 1'b0;
  logic        pin_out, evt_set;
  logic [15:0] cap_q;
  logic [7:0]  mode_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cc_channel uut (
    .clk(clk), .rst(rst), .cnt_val(cnt), .pin_in(pin_in),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .lo_we(lo_we), .hi_we(hi_we), .byte_wdata(byte_wdata),
    .pin_set_we(pin_set_we), .pin_set_val(pin_set_val),
    .pin_out(pin_out), .evt_set(evt_set), .cap_q(cap_q), .mode_q(mode_q)
  );

  // mode, expected strobe count, expected toggle count (R5, R7, R10)
  localparam logic [8:0] VEC [8] = '{
    {7'h48, 1'b1, 1'b0}, {7'h4C, 1'b1, 1'b1}, {7'h4D, 1'b1, 1'b1},
    {7'h4E, 1'b0, 1'b0}, {7'h44, 1'b0, 1'b0}, {7'h08, 1'b0, 1'b0},
    {7'h68, 1'b0, 1'b0}, {7'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [6:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] b);
    @(negedge clk); lo_we = 1'b1; byte_wdata = b;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] b);
    @(negedge clk); hi_we = 1'b1; byte_wdata = b;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic ramp(input logic [15:0] start, input int n, output int nev, output int ntog);
    logic p;
    nev = 0; ntog = 0;
    @(negedge clk); cnt = start; p = pin_out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      nev += int'(evt_set);
      if (pin_out != p) ntog++;
      p = pin_out;
      cnt = cnt + 16'd1;
    end
  endtask

  task automatic hold(input int n, output int nev);
    nev = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      nev += int'(evt_set);
    end
  endtask

  task automatic pin_capture(input logic [15:0] c, input logic lvl, output int nev);
    @(negedge clk); cnt = c; pin_in = lvl;
    hold(6, nev);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nev, ntog;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin", pin_out, 0);
    check("R1 evt", evt_set, 0);
    check("R1 val", cap_q, 0);
    check("R1 mode", mode_q, 0);

    // mode table: compare value 0x0A05
    for (int i = 0; i < 8; i++) begin
      wr_lo(8'h05);
      wr_hi(8'h0A);
      wr_mode(VEC[i][8:2]);
      ramp(16'h0A00, 12, nev, ntog);
      check($sformatf("R5/R7/R10 evt mode %0h", VEC[i][8:2]), nev, VEC[i][1]);
      check($sformatf("R7/R10 toggle mode %0h", VEC[i][8:2]), ntog, VEC[i][0]);
      @(negedge clk); cnt = 16'h0;
    end

    // R9 byte writes and enable interlock
    wr_mode(7'h48);
    wr_lo(8'h34);
    check("R9 lo clears enable", mode_q[6], 0);
    check("R9 lo byte", cap_q[7:0], 8'h34);
    ramp(16'h0A30, 10, nev, ntog);
    check("R9 no match while disabled", nev, 0);
    wr_hi(8'h0A);
    check("R9 hi sets enable", mode_q, 8'h48);
    check("R9 value", cap_q, 16'h0A34);
    ramp(16'h0A30, 10, nev, ntog);
    check("R9 match after hi", nev, 1);

    // R6 held counter
    @(negedge clk); cnt = 16'h0A34;
    hold(8, nev);
    check("R6 one strobe while held", nev, 1);

    // R8 preset and preset-vs-toggle
    wr_mode(7'h4C);
    @(negedge clk); cnt = 16'h0; pin_set_we = 1'b1; pin_set_val = 1'b1;
    @(negedge clk); pin_set_we = 1'b0;
    check("R8 preset high", pin_out, 1);
    ramp(16'h0A30, 10, nev, ntog);
    check("R7 toggle to low", pin_out, 0);
    @(negedge clk); cnt = 16'h0;
    @(negedge clk); cnt = 16'h0A34; pin_set_we = 1'b1; pin_set_val = 1'b0;
    @(negedge clk); pin_set_we = 1'b0;
    check("R8 preset wins", pin_out, 0);
    check("R8 match still strobes", evt_set, 1);

    // captures
    wr_mode(7'h20);
    pin_capture(16'h1111, 1'b1, nev);
    check("R2 rising strobe", nev, 1);
    check("R2 rising value", cap_q, 16'h1111);
    wr_mode(7'h10);
    pin_capture(16'h2222, 1'b0, nev);
    check("R3 falling value", cap_q, 16'h2222);
    pin_capture(16'h3333, 1'b1, nev);
    check("R3 rising ignored strobe", nev, 0);
    check("R3 rising ignored value", cap_q, 16'h2222);
    wr_mode(7'h30);
    pin_capture(16'h4444, 1'b0, nev);
    check("R4 fall value", cap_q, 16'h4444);
    pin_capture(16'h5555, 1'b1, nev);
    check("R4 overwrite", cap_q, 16'h5555);
    check("R4 strobe", nev, 1);

    // R2 latency: value taken at third edge
    wr_mode(7'h20);
    @(negedge clk); pin_in = 1'b0;
    hold(4, nev);
    @(negedge clk); cnt = 16'h0100; pin_in = 1'b1;
    @(negedge clk); cnt = 16'h0101;
    @(negedge clk); cnt = 16'h0102;
    @(negedge clk); cnt = 16'h0103;
    check("R2 latency value", cap_q, 16'h0102);
    check("R2 latency strobe", evt_set, 1);

    // R11
    wr_mode(7'h7F);
    check("R11 readback", mode_q, 8'h7F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule